// File: doc/BRIEF.md
# UART Transmit Queue with Empty and End Flags

This block is the transmit-side byte queue of a UART. The CPU or a DMA engine writes bytes into a 16-entry first-in first-out store. Each frame tick removes one byte and hands it to the serializer, but only while transmit is enabled. In loopback mode the byte goes to the receive path instead. A count of queued bytes is always visible.

Two status flags describe the queue. The low-water flag `tdfe` is set when a removal leaves the count at or below a programmable trigger. The drained flag `tend` is set when a removal empties the queue. A DMA write clears `tend` at once. It also clears `tdfe` when the count after the write is above the trigger. A CPU write leaves both flags alone, so software clears them through its own path. Clearing the queue sets both flags. A transmit interrupt follows the low-water events when it is enabled.

Because `tend` can never be set while `tdfe` is clear, the flags are held as a three-state machine:
- `FLG_DRAINED`: both flags set.
- `FLG_LOW`: only `tdfe` set.
- `FLG_ARMED`: neither flag set.

The transitions are:
- `clear` → `FLG_DRAINED` (from any state; highest priority).
- `dma_fill_low`: `FLG_DRAINED` → `FLG_LOW`, on a DMA write that leaves the count at or below the trigger.
- `dma_fill_high`: `FLG_DRAINED` or `FLG_LOW` → `FLG_ARMED`, on a DMA write that leaves the count above the trigger.
- `drain_low`: `FLG_ARMED` → `FLG_LOW`, on a removal that leaves the count at or below the trigger.
- `drain_empty`: `FLG_LOW` or `FLG_ARMED` → `FLG_DRAINED`, on a removal that leaves the count at zero.

Top module: `uart_txq_top`

## Requirements
- R1: After reset, `fill_count` is 0, `tend` and `tdfe` are 1, and `tx_irq`, `tx_valid` and `lb_valid` are 0.
- R2: The queue holds at most 16 bytes. A write while 16 bytes are queued is discarded: the count, the stored bytes and the flags are all unchanged, even for a DMA write.
- R3: Bytes leave in write order, one per `frame_tick`, only while `tx_enable` is 1 and the queue is not empty. The byte appears on `tx_data` with `tx_valid` high for exactly one cycle, in the cycle after the tick.
- R4: `trig_sel` values 0, 1, 2 and 3 select trigger levels of 8, 4, 2 and 1 bytes.
- R5: When a removal leaves the count at or below the trigger, `tdfe` becomes 1 in the following cycle. If `irq_enable` is 1, `tx_irq` also becomes 1 in that cycle.
- R6: When a removal leaves the count at 0, `tend` also becomes 1. `tend` is never 1 while `tdfe` is 0.
- R7: An accepted DMA write (`wr_en`=1, `wr_dma`=1) clears `tend`. If the count after the write is above the trigger, it also clears `tdfe` and `tx_irq`. A CPU write (`wr_dma`=0) changes neither flag.
- R8: `fifo_clear` empties the queue, sets the count to 0 and sets both flags. If `irq_enable` is 1, it also raises `tx_irq`. It takes priority over a write or removal in the same cycle.
- R9: With `loopback`=1, a removed byte pulses `lb_valid` instead of `tx_valid`, with the byte on `tx_data`. This happens only if `rx_enable` is 1. Otherwise the byte is removed and neither strobe pulses.
- R10: When `irq_enable` is 0, `tx_irq` is 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_dma | input | 1 | 1 = write comes from DMA, 0 = from the CPU |
| wr_data | input | 8 | Byte to queue |
| frame_tick | input | 1 | One pulse per serial frame time |
| tx_enable | input | 1 | Allows removal on frame ticks |
| fifo_clear | input | 1 | Empties the queue and sets the flags |
| trig_sel | input | 2 | Trigger select: 0→8, 1→4, 2→2, 3→1 |
| irq_enable | input | 1 | Transmit interrupt enable |
| loopback | input | 1 | Routes removed bytes to the receive path |
| rx_enable | input | 1 | Receive enable, gates the loopback strobe |
| tx_data | output | 8 | Last removed byte |
| tx_valid | output | 1 | One-cycle strobe, byte for the serializer |
| lb_valid | output | 1 | One-cycle strobe, byte for the receive path |
| fill_count | output | 5 | Number of queued bytes |
| tend | output | 1 | Transmission-end flag |
| tdfe | output | 1 | Low-water (data-empty) flag |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
A wrong flag state shows at the `tend` and `tdfe` ports in the cycle after the write, removal or clear that should have moved it. A missed low-water transition also shows as a missing `tx_irq` in that same cycle. Pointer or count corruption shows on `fill_count` one cycle after the event. It then shows on `tx_data`, as an out-of-order byte or a strobe on an empty queue, at the next enabled frame tick. The directed scenarios drain the queue one tick at a time under every trigger select. This puts each threshold crossing under a check in the cycle it occurs.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [1:0] {
        FLG_DRAINED = 2'd0,
        FLG_LOW     = 2'd1,
        FLG_ARMED   = 2'd2
    } flag_state_t;

    // Trigger level halves with each step of the select code.
    function automatic int trig_level(input int base, input logic [1:0] sel);
        return base >> sel;
    endfunction
endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_next,
    output logic          push_ok
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign push_ok    = push && (count != FULL);
    assign dout       = mem[rd_ptr];
    assign count_next = clear ? '0 : count + CW'(push_ok) - CW'(pop);

    always_ff @(posedge clk) begin
        if (push_ok && !clear)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop)     rd_ptr <= bump(rd_ptr);
            count <= count_next;
        end
    end
endmodule

// File: rtl/txq_flag_fsm.sv
module txq_flag_fsm
    import txq_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          pop_evt,
    input  logic          dma_evt,
    input  logic [CW-1:0] count_next,
    input  logic [CW-1:0] trig,
    input  logic          irq_en,
    output logic          tend,
    output logic          tdfe,
    output logic          irq
);
    flag_state_t state, state_nxt;
    logic at_or_below, drained;

    assign at_or_below = (count_next <= trig);
    assign drained     = (count_next == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FLG_DRAINED;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        if (clear) begin
            state_nxt = FLG_DRAINED;
        end else begin
            unique case (state)
                FLG_DRAINED: begin
                    if (dma_evt)
                        state_nxt = at_or_below ? FLG_LOW : FLG_ARMED;
                end
                FLG_LOW: begin
                    if (pop_evt && drained)
                        state_nxt = FLG_DRAINED;
                    else if (dma_evt && !at_or_below)
                        state_nxt = FLG_ARMED;
                end
                FLG_ARMED: begin
                    if (pop_evt && drained)
                        state_nxt = FLG_DRAINED;
                    else if (pop_evt && at_or_below)
                        state_nxt = FLG_LOW;
                end
                default: state_nxt = FLG_DRAINED;
            endcase
        end
    end

    // Flag outputs
    always_comb begin
        unique case (state)
            FLG_DRAINED: begin tend = 1'b1; tdfe = 1'b1; end
            FLG_LOW:     begin tend = 1'b0; tdfe = 1'b1; end
            default:     begin tend = 1'b0; tdfe = 1'b0; end
        endcase
    end

    // Interrupt request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (!irq_en)
            irq <= 1'b0;
        else if (clear || (pop_evt && at_or_below))
            irq <= 1'b1;
        else if (dma_evt && !at_or_below)
            irq <= 1'b0;
    end
endmodule

// File: rtl/uart_txq_top.sv
module uart_txq_top
    import txq_pkg::*;
#(
    parameter int W         = 8,
    parameter int DEPTH     = 16,
    parameter int TRIG_BASE = 8,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_dma,
    input  logic [W-1:0]  wr_data,
    input  logic          frame_tick,
    input  logic          tx_enable,
    input  logic          fifo_clear,
    input  logic [1:0]    trig_sel,
    input  logic          irq_enable,
    input  logic          loopback,
    input  logic          rx_enable,
    output logic [W-1:0]  tx_data,
    output logic          tx_valid,
    output logic          lb_valid,
    output logic [CW-1:0] fill_count,
    output logic          tend,
    output logic          tdfe,
    output logic          tx_irq
);
    logic [W-1:0]  head_byte;
    logic [CW-1:0] cnt_nxt, trig;
    logic          pop, push, push_ok, dma_evt;

    assign trig    = CW'(trig_level(TRIG_BASE, trig_sel));
    assign pop     = frame_tick && tx_enable && (fill_count != '0) && !fifo_clear;
    assign push    = wr_en && !fifo_clear;
    assign dma_evt = push_ok && wr_dma && !fifo_clear;

    txq_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (fifo_clear),
        .push       (push),
        .pop        (pop),
        .din        (wr_data),
        .dout       (head_byte),
        .count      (fill_count),
        .count_next (cnt_nxt),
        .push_ok    (push_ok)
    );

    txq_flag_fsm #(.CW(CW)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (fifo_clear),
        .pop_evt    (pop),
        .dma_evt    (dma_evt),
        .count_next (cnt_nxt),
        .trig       (trig),
        .irq_en     (irq_enable),
        .tend       (tend),
        .tdfe       (tdfe),
        .irq        (tx_irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_data  <= '0;
            tx_valid <= 1'b0;
            lb_valid <= 1'b0;
        end else begin
            if (pop) tx_data <= head_byte;
            tx_valid <= pop && !loopback;
            lb_valid <= pop && loopback && rx_enable;
        end
    end
endmodule

// File: rtl/txq_checker.sv
module txq_checker #(
    parameter int CW    = 5,
    parameter int DEPTH = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          wr_dma,
    input logic          frame_tick,
    input logic          tx_enable,
    input logic          fifo_clear,
    input logic          irq_enable,
    input logic          tx_valid,
    input logic          lb_valid,
    input logic [CW-1:0] fill_count,
    input logic          tend,
    input logic          tdfe,
    input logic          tx_irq
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CW'(DEPTH)); // R2

    AST_POP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid || lb_valid) |-> $past(frame_tick && tx_enable)); // R3

    AST_IRQ_WITH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_irq) |-> tdfe); // R5

    AST_END_IMPLIES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tend |-> tdfe); // R6

    AST_CPU_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_dma && !frame_tick && !fifo_clear) |=> ($stable(tend) && $stable(tdfe))); // R7

    AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear |=> (fill_count == '0 && tend && tdfe)); // R8

    AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && lb_valid)); // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_enable |=> !tx_irq); // R10
endmodule

bind uart_txq_top txq_checker #(.CW(CW), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_dma     (wr_dma),
    .frame_tick (frame_tick),
    .tx_enable  (tx_enable),
    .fifo_clear (fifo_clear),
    .irq_enable (irq_enable),
    .tx_valid   (tx_valid),
    .lb_valid   (lb_valid),
    .fill_count (fill_count),
    .tend       (tend),
    .tdfe       (tdfe),
    .tx_irq     (tx_irq)
);

// File: tb/tb_uart_txq_top.sv
module tb_uart_txq_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, wr_dma = 0, frame_tick = 0, tx_enable = 0, fifo_clear = 0;
    logic [7:0] wr_data = '0;
    logic [1:0] trig_sel = '0;
    logic       irq_enable = 0, loopback = 0, rx_enable = 0;
    logic [7:0] tx_data;
    logic       tx_valid, lb_valid, tend, tdfe, tx_irq;
    logic [4:0] fill_count;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_txq_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dma(wr_dma), .wr_data(wr_data),
        .frame_tick(frame_tick), .tx_enable(tx_enable), .fifo_clear(fifo_clear),
        .trig_sel(trig_sel), .irq_enable(irq_enable), .loopback(loopback),
        .rx_enable(rx_enable), .tx_data(tx_data), .tx_valid(tx_valid),
        .lb_valid(lb_valid), .fill_count(fill_count), .tend(tend), .tdfe(tdfe),
        .tx_irq(tx_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, let the posedge pass, return at next negedge.
    task automatic step(input bit wr, input bit dma, input logic [7:0] d,
                        input bit tick, input bit clr);
        wr_en = wr; wr_dma = dma; wr_data = d; frame_tick = tick; fifo_clear = clr;
        @(negedge clk);
        wr_en = 0; wr_dma = 0; frame_tick = 0; fifo_clear = 0;
    endtask

    task automatic t_reset();
        check("R1 count", fill_count, 0);
        check("R1 tend", tend, 1);
        check("R1 tdfe", tdfe, 1);
        check("R1 irq", tx_irq, 0);
        check("R1 strobes", tx_valid | lb_valid, 0);
    endtask

    task automatic t_fill_and_drain();
        irq_enable = 0; tx_enable = 0; loopback = 0; trig_sel = 0;
        step(0, 0, 0, 0, 1);
        for (int i = 0; i < 17; i++) step(1, 0, 8'hA0 + 8'(i), 0, 0);
        check("R2 count full", fill_count, 16);
        check("R7 cpu tend", tend, 1);
        check("R7 cpu tdfe", tdfe, 1);
        step(1, 1, 8'h55, 0, 0);
        check("R2 dma on full count", fill_count, 16);
        check("R2 dma on full tend", tend, 1);
        step(0, 0, 0, 1, 0);
        check("R3 disabled no pop", fill_count, 16);
        check("R3 disabled no valid", tx_valid, 0);
        tx_enable = 1;
        for (int i = 0; i < 16; i++) begin
            step(0, 0, 0, 1, 0);
            check("R3 valid", tx_valid, 1);
            check("R3 order", tx_data, 8'hA0 + 8'(i));
            step(0, 0, 0, 0, 0);
            check("R3 pulse", tx_valid, 0);
        end
        check("R6 tend empty", tend, 1);
        step(0, 0, 0, 1, 0);
        check("R3 empty no valid", tx_valid, 0);
        tx_enable = 0;
    endtask

    task automatic t_trigger(input logic [1:0] sel);
        int trig;
        trig = 8 >> sel;
        trig_sel = sel; irq_enable = 1; tx_enable = 0;
        step(0, 0, 0, 0, 1);
        for (int i = 0; i < 10; i++) step(1, 1, 8'(i), 0, 0);
        check("R7 dma tend", tend, 0);
        check("R7 dma tdfe", tdfe, 0);
        check("R7 dma irq", tx_irq, 0);
        tx_enable = 1;
        for (int c = 9; c >= 0; c--) begin
            step(0, 0, 0, 1, 0);
            check("R4 R5 tdfe", tdfe, (c <= trig) ? 1 : 0);
            check("R5 irq", tx_irq, (c <= trig) ? 1 : 0);
            check("R6 tend", tend, (c == 0) ? 1 : 0);
        end
        tx_enable = 0;
    endtask

    task automatic t_dma_below();
        trig_sel = 0;
        step(0, 0, 0, 0, 1);
        step(1, 1, 8'h11, 0, 0);
        check("R7 dma low tend", tend, 0);
        check("R7 dma low tdfe", tdfe, 1);
    endtask

    task automatic t_irq_mask();
        irq_enable = 1;
        step(0, 0, 0, 0, 1);
        check("R8 clear irq", tx_irq, 1);
        irq_enable = 0;
        step(0, 0, 0, 0, 0);
        check("R10 irq dropped", tx_irq, 0);
    endtask

    task automatic t_loopback();
        tx_enable = 0; loopback = 1; rx_enable = 1;
        step(0, 0, 0, 0, 1);
        step(1, 0, 8'h3C, 0, 0);
        step(1, 0, 8'h5A, 0, 0);
        tx_enable = 1;
        step(0, 0, 0, 1, 0);
        check("R9 lb_valid", lb_valid, 1);
        check("R9 no tx_valid", tx_valid, 0);
        check("R9 data", tx_data, 8'h3C);
        rx_enable = 0;
        step(0, 0, 0, 1, 0);
        check("R9 rx off strobe", lb_valid | tx_valid, 0);
        check("R9 rx off count", fill_count, 0);
        loopback = 0; tx_enable = 0;
    endtask

    task automatic t_clear_priority();
        tx_enable = 1;
        step(1, 1, 8'h01, 0, 0);
        step(1, 1, 8'h02, 0, 0);
        step(1, 1, 8'h03, 1, 1);
        check("R8 clear count", fill_count, 0);
        check("R8 clear flags", {tend, tdfe}, 3);
        check("R8 clear no valid", tx_valid, 0);
        tx_enable = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fill_and_drain();
        for (int s = 0; s < 4; s++) t_trigger(2'(s));
        t_dma_below();
        t_irq_mask();
        t_loopback();
        t_clear_priority();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule